// File: doc/BRIEF.md
# PWM Gate Output Conditioning Stage

This block sits between a three-phase PWM timing unit and the six gate-drive pins (high and low side of each phase). Each clock it takes the six raw ON/OFF commands from the timing unit. It can force the low-side commands ON for switched reluctance machines, and it can swap the high and low commands of any phase. The result is held in a register. After that register, a shutdown flag gates the pins without waiting for a clock edge, and a final inversion sets the electrical polarity of each pin.

Two board straps configure the stage. The polarity strap selects whether a high or a low pin level turns a power device on. The reluctance strap is active low and is the only way to enable reluctance mode. Both straps pass through synchronizer flops. Those flops reset to the levels an unconnected strap gives: active-high outputs and reluctance mode off. The synchronized strap levels and the shutdown flag can be read on a status word. A 3-bit crossover register, written through a simple write strobe, holds one swap bit per phase.

Top module: `pwm_gate_stage`

## Requirements
- R1: While and after reset, the crossover register is 0, the pins read OFF, and the status word reads 3'b110 (polarity high, reluctance off, no shutdown) whatever the strap levels are.
- R2: With the polarity strap high, reluctance off and no shutdown, gate_hi[i]/gate_lo[i] equal cmd_hi[i]/cmd_lo[i] (1 = device on).
- R3: With the polarity strap low, every pin is the inverse of the value R2 would give, so 0 turns a device on.
- R4: Status bit 2 is the synchronized polarity strap (0 = strap low), bit 1 is the synchronized reluctance strap, and bit 0 is the shutdown flag.
- R5: With rel_strap_n low, each low-side command is forced ON regardless of cmd_lo, while the high-side commands still follow cmd_hi.
- R6: Bit i of the crossover register, loaded from xover_wdata when xover_we is 1, swaps phase i: the (possibly forced) low command drives gate_hi[i] and the high command drives gate_lo[i].
- R7: With reluctance off, shutdown = 1 sets all six pins to the OFF level (0 when the polarity strap is high, 1 when it is low) in the same cycle, with no clock edge needed.
- R8: With reluctance on and shutdown = 1, the pin that carries a forced-ON signal stays ON: the low pin of an uncrossed phase, or the high pin of a crossed phase. Every other pin goes OFF.
- R9: When xover_we is 0, xover_wdata has no effect on the crossover register.
- R10: A change on cmd_hi/cmd_lo reaches the pins after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | 3 | Raw high-side ON commands, one per phase |
| cmd_lo | input | 3 | Raw low-side ON commands, one per phase |
| shutdown | input | 1 | Shutdown request, gates the pins combinationally |
| pol_strap | input | 1 | Polarity strap, 1 = active-high pins |
| rel_strap_n | input | 1 | Reluctance strap, 0 = reluctance mode on |
| xover_we | input | 1 | Crossover register write strobe |
| xover_wdata | input | 3 | Crossover bits, one per phase |
| gate_hi | output | 3 | High-side gate pins |
| gate_lo | output | 3 | Low-side gate pins |
| status | output | 3 | {polarity strap, reluctance strap, shutdown} |

## Verification
Random command words are run across all combinations of polarity, reluctance mode, crossover mask and shutdown. Each combination separates a different stage: reluctance forcing against crossover routing shows whether forcing happens before the swap, and shutdown with both mode settings shows whether the surviving pins follow the routed forced signal. Directed cases add three checks. A shutdown toggle is checked with no clock edge in between, to prove the OFF path is combinational. A command change is checked just before and just after one edge, to pin the latency. Writes with the strobe low check that the crossover register keeps its value.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
  parameter int unsigned STATUS_W = 3;
  parameter int unsigned POL_BIT  = 2;
  parameter int unsigned REL_BIT  = 1;
  parameter int unsigned SD_BIT   = 0;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= RESET_VAL;
        else     s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] s;
      always_ff @(posedge clk) begin
        if (rst) s <= {STAGES{RESET_VAL}};
        else     s <= {s[STAGES-2:0], d};
      end
      assign q = s[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/phase_leg.sv
module phase_leg (
  input  logic clk,
  input  logic rst,
  input  logic raw_hi,
  input  logic raw_lo,
  input  logic xov,
  input  logic rel_en,
  output logic hi_q,
  output logic lo_q,
  output logic keep_hi_q,
  output logic keep_lo_q
);
  logic lo_forced;
  logic hi_route, lo_route;

  assign lo_forced = rel_en ? 1'b1 : raw_lo;
  assign hi_route  = xov ? lo_forced : raw_hi;
  assign lo_route  = xov ? raw_hi : lo_forced;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= 1'b0;
      lo_q      <= 1'b0;
      keep_hi_q <= 1'b0;
      keep_lo_q <= 1'b0;
    end else begin
      hi_q      <= hi_route;
      lo_q      <= lo_route;
      keep_hi_q <= rel_en & xov;
      keep_lo_q <= rel_en & ~xov;
    end
  end

  // R5
  rel_force_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !xov) |=> lo_q);

  // R6
  xover_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (xov && !rel_en) |=> (hi_q == $past(raw_lo)) && (lo_q == $past(raw_hi)));

  // R10
  straight_path_chk: assert property (@(posedge clk) disable iff (rst)
    !xov |=> hi_q == $past(raw_hi));
endmodule

// File: rtl/gate_drive.sv
module gate_drive #(
  parameter int unsigned N_PHASE = 3
) (
  input  logic [N_PHASE-1:0] hi_cmd,
  input  logic [N_PHASE-1:0] lo_cmd,
  input  logic [N_PHASE-1:0] keep_hi,
  input  logic [N_PHASE-1:0] keep_lo,
  input  logic               sd,
  input  logic               pol_high,
  output logic [N_PHASE-1:0] pin_hi,
  output logic [N_PHASE-1:0] pin_lo
);
  logic [N_PHASE-1:0] on_hi, on_lo;

  always_comb begin
    on_hi = sd ? keep_hi : hi_cmd;
    on_lo = sd ? keep_lo : lo_cmd;
    pin_hi = pol_high ? on_hi : ~on_hi;
    pin_lo = pol_high ? on_lo : ~on_lo;
  end
endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage
  import pwm_stage_pkg::*;
#(
  parameter int unsigned N_PHASE     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PHASE-1:0]  cmd_hi,
  input  logic [N_PHASE-1:0]  cmd_lo,
  input  logic                shutdown,
  input  logic                pol_strap,
  input  logic                rel_strap_n,
  input  logic                xover_we,
  input  logic [N_PHASE-1:0]  xover_wdata,
  output logic [N_PHASE-1:0]  gate_hi,
  output logic [N_PHASE-1:0]  gate_lo,
  output logic [STATUS_W-1:0] status
);
  localparam logic [STATUS_W-1:0] STATUS_RST =
    STATUS_W'((1 << POL_BIT) | (1 << REL_BIT));

  logic               pol_s, rel_n_s, rel_en;
  logic [N_PHASE-1:0] xover_q;
  logic [N_PHASE-1:0] hi_q, lo_q, keep_hi_q, keep_lo_q;

  strap_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pol_sync (
    .clk(clk), .rst(rst), .d(pol_strap), .q(pol_s)
  );
  strap_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rel_sync (
    .clk(clk), .rst(rst), .d(rel_strap_n), .q(rel_n_s)
  );
  assign rel_en = ~rel_n_s;

  always_ff @(posedge clk) begin
    if (rst)           xover_q <= '0;
    else if (xover_we) xover_q <= xover_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= STATUS_RST;
    else begin
      status          <= '0;
      status[POL_BIT] <= pol_s;
      status[REL_BIT] <= rel_n_s;
      status[SD_BIT]  <= shutdown;
    end
  end

  generate
    for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
      phase_leg u_leg (
        .clk       (clk),
        .rst       (rst),
        .raw_hi    (cmd_hi[p]),
        .raw_lo    (cmd_lo[p]),
        .xov       (xover_q[p]),
        .rel_en    (rel_en),
        .hi_q      (hi_q[p]),
        .lo_q      (lo_q[p]),
        .keep_hi_q (keep_hi_q[p]),
        .keep_lo_q (keep_lo_q[p])
      );
    end
  endgenerate

  gate_drive #(.N_PHASE(N_PHASE)) u_drive (
    .hi_cmd   (hi_q),
    .lo_cmd   (lo_q),
    .keep_hi  (keep_hi_q),
    .keep_lo  (keep_lo_q),
    .sd       (shutdown),
    .pol_high (pol_s),
    .pin_hi   (gate_hi),
    .pin_lo   (gate_lo)
  );

  // R1
  xover_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> xover_q == '0);

  // R7
  shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
    (shutdown && rel_n_s && keep_hi_q == '0 && keep_lo_q == '0) |->
      (gate_hi == {N_PHASE{~pol_s}}) && (gate_lo == {N_PHASE{~pol_s}}));

  // R9
  xover_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xover_we |=> $stable(xover_q));

  // R8
  keep_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({keep_hi_q[0], keep_lo_q[0]}));
endmodule

// File: tb/pwm_gate_stage_tb.sv
module pwm_gate_stage_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_hi = '0, cmd_lo = '0;
  logic       shutdown = 1'b0;
  logic       pol_strap = 1'b0;
  logic       rel_strap_n = 1'b0;
  logic       xover_we = 1'b0;
  logic [2:0] xover_wdata = '0;
  logic [2:0] gate_hi, gate_lo;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  logic [2:0] cur_x = '0;

  always #5 clk = ~clk;

  pwm_gate_stage u_dut (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .shutdown(shutdown), .pol_strap(pol_strap), .rel_strap_n(rel_strap_n),
    .xover_we(xover_we), .xover_wdata(xover_wdata),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .status(status)
  );

  function automatic logic [5:0] model(input logic [2:0] h, input logic [2:0] l,
                                       input logic [2:0] x, input logic rel_n,
                                       input logic pol, input logic sd);
    logic [2:0] oh, ol;
    for (int p = 0; p < 3; p++) begin
      logic lf, a, b, kh, kl;
      lf = (!rel_n) ? 1'b1 : l[p];
      a  = x[p] ? lf : h[p];
      b  = x[p] ? h[p] : lf;
      kh = !rel_n && x[p];
      kl = !rel_n && !x[p];
      if (sd) begin a = kh; b = kl; end
      oh[p] = pol ? a : !a;
      ol[p] = pol ? b : !b;
    end
    return {oh, ol};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    #1;
  endtask

  task automatic write_x(input logic [2:0] v);
    @(negedge clk);
    xover_we = 1'b1; xover_wdata = v;
    @(negedge clk);
    xover_we = 1'b0;
    cur_x = v;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cmd_hi = 3'b101; cmd_lo = 3'b011;
    repeat (3) @(negedge clk);
    #1;
    // R1: defaults during reset, straps ignored
    check("R1 status", {3'b000, status}, {3'b000, 3'b110});
    check("R1 pins", {gate_hi, gate_lo}, 6'b000000);
    @(negedge clk);
    rst = 1'b0;
    pol_strap = 1'b1; rel_strap_n = 1'b1; cmd_hi = 3'b000; cmd_lo = 3'b000;
    settle();
    // R1: crossover cleared, so straight routing
    cmd_hi = 3'b001; cmd_lo = 3'b100;
    settle();
    check("R1 xover zero", {gate_hi, gate_lo}, {3'b001, 3'b100});
    // R2
    check("R2 passthru", {gate_hi, gate_lo}, model(3'b001, 3'b100, 3'b000, 1'b1, 1'b1, 1'b0));
    // R3
    pol_strap = 1'b0;
    settle();
    check("R3 active low", {gate_hi, gate_lo}, {3'b110, 3'b011});
    // R4
    check("R4 status", {3'b000, status}, {3'b000, 3'b010});
    rel_strap_n = 1'b0; shutdown = 1'b1;
    settle();
    check("R4 status rel sd", {3'b000, status}, {3'b000, 3'b001});
    shutdown = 1'b0; pol_strap = 1'b1;
    settle();
    // R5
    check("R5 forcing", {gate_hi, gate_lo}, {3'b001, 3'b111});
    // R6: cross phase 1
    write_x(3'b010);
    settle();
    check("R6 swap", {gate_hi, gate_lo}, {3'b011, 3'b101});
    // R8
    shutdown = 1'b1;
    #1;
    check("R8 keep forced", {gate_hi, gate_lo}, {3'b010, 3'b101});
    shutdown = 1'b0;
    // R9: data without strobe
    @(negedge clk);
    xover_wdata = 3'b101;
    settle();
    check("R9 xover hold", {gate_hi, gate_lo}, model(3'b001, 3'b100, 3'b010, 1'b0, 1'b1, 1'b0));
    // R7: combinational gating, no edge between
    rel_strap_n = 1'b1; cmd_hi = 3'b111; cmd_lo = 3'b111; write_x(3'b000);
    settle();
    @(posedge clk);
    #2;
    shutdown = 1'b1;
    #1;
    check("R7 immediate off", {gate_hi, gate_lo}, 6'b000000);
    shutdown = 1'b0;
    #1;
    check("R7 release", {gate_hi, gate_lo}, 6'b111111);
    // R10: one edge latency
    @(negedge clk);
    cmd_hi = 3'b010; cmd_lo = 3'b001;
    #1;
    check("R10 before edge", {gate_hi, gate_lo}, 6'b111111);
    @(negedge clk);
    #1;
    check("R10 after edge", {gate_hi, gate_lo}, {3'b010, 3'b001});
    // random sweep: R2 R3 R5 R6 R7 R8
    for (int it = 0; it < 400; it++) begin
      logic [2:0] h, l, x;
      logic pl, rn, sd;
      h = 3'($urandom); l = 3'($urandom); x = 3'($urandom);
      pl = 1'($urandom); rn = 1'($urandom); sd = 1'($urandom);
      write_x(x);
      cmd_hi = h; cmd_lo = l; pol_strap = pl; rel_strap_n = rn; shutdown = sd;
      settle();
      check("R2/R3/R5/R6/R7/R8 random", {gate_hi, gate_lo}, model(h, l, cur_x, rn, pl, sd));
      check("R4 random status", {3'b000, status}, {3'b000, pl, rn, sd});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule